// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a one-cycle execution unit for packed integer data. Each operand is 128 bits wide and is split into equal lanes of 32, 16 or 8 bits. One operation is applied to every lane at the same time. No carry, borrow or compare result passes from one lane into the next.

The unit supports the following operations:
- lane-wise wrapping add and subtract;
- signed minimum and maximum;
- logical left, logical right and arithmetic right shifts by a shared amount;
- a per-lane leading-zero count;
- four bitwise logic functions over the full 128 bits;
- a byte-granular funnel extract from the 256-bit joining of both operands.

A caller presents both sources, an operation code, a lane size and a shift amount together with a valid strobe. The result is registered and appears on the next clock edge with its own valid flag. The result register keeps its value on cycles without a valid input.

Top module: `lane_alu128`

## Requirements
- R1: `laneSel` picks the lane width: 0 selects four 32-bit lanes, 1 selects eight 16-bit lanes, and 2 or 3 selects sixteen 8-bit lanes. Lane i occupies bits [i*W+W-1 : i*W].
- R2: Opcode 0 adds and opcode 1 subtracts (A minus B), lane by lane. Each lane wraps modulo 2^W and no carry or borrow crosses a lane boundary.
- R3: Opcode 2 returns, per lane, the smaller of the two lanes taken as signed two's-complement numbers. Opcode 3 returns the larger one.
- R4: Opcodes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B) over all 128 bits, whatever the lane size.
- R5: Opcodes 8, 9 and 10 shift each A lane left logically, right logically and right arithmetically. All three use the low log2(W) bits of `shAmt`.
- R6: Opcode 11 writes, zero-extended into each lane, the number of leading zero bits of that A lane. An all-zero lane gives W.
- R7: Opcode 12 forms {A,B} with A as the upper half and shifts it right by 8*n bits, where n is `shAmt[3:0]`. It returns the low 128 bits of that value.
- R8: `outValid` is high exactly one clock after `inValid` was high. A synchronous active-high `rst` clears `outValid` and `result`.
- R9: When `inValid` is low, `result` keeps its previous value.
- R10: Opcodes 13 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opA | input | 128 | First source operand |
| opB | input | 128 | Second source operand |
| opCode | input | 4 | Operation select |
| laneSel | input | 2 | Lane width select |
| shAmt | input | 5 | Shift amount (lane shifts) / byte count (funnel) |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 128 | Registered 128-bit result |

## Verification
The cases that are hardest to reach are lanes where a carry, borrow or sign would leak into the neighbouring lane, and signed comparisons where the two values differ only in the top bit. Uniform random data seldom produces these. The stimulus therefore mixes directed operands with random ones: all-ones, alternating sign patterns, single-bit lanes and lanes of zero. Every opcode is then crossed with every lane size and with extreme shift amounts. A behavioural reference model that works lane by lane with integers predicts every cycle, including the cycles where the result must be held.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MIN = 4'd2, OP_MAX = 4'd3,
    OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_NOR = 4'd7,
    OP_SLL = 4'd8, OP_SRL = 4'd9, OP_SRA = 4'd10, OP_LZC = 4'd11,
    OP_FUN = 4'd12
  } aluOp_e;

  typedef struct packed {
    logic       load;
    logic       doArith;
    logic       doSub;
    logic       doMin;
    logic       doMax;
    logic       doLogic;
    logic [1:0] logicSel;
    logic       doShift;
    logic [1:0] shiftSel;
    logic       doLzc;
    logic       doFunnel;
    logic [1:0] widthIdx;
  } aluCtl_t;
endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [3:0]          opCode,
  input  logic [1:0]          laneSel,
  output aluCtl_t             ctl,
  output logic                outValid
);
  always_comb begin
    ctl          = '0;
    ctl.load     = inValid;
    ctl.widthIdx = (laneSel[1]) ? 2'd2 : {1'b0, laneSel[0]};
    case (aluOp_e'(opCode))
      OP_ADD: ctl.doArith = 1'b1;
      OP_SUB: begin ctl.doArith = 1'b1; ctl.doSub = 1'b1; end
      OP_MIN: ctl.doMin = 1'b1;
      OP_MAX: ctl.doMax = 1'b1;
      OP_AND: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd0; end
      OP_OR:  begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd1; end
      OP_XOR: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd2; end
      OP_NOR: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd3; end
      OP_SLL: begin ctl.doShift = 1'b1; ctl.shiftSel = 2'd0; end
      OP_SRL: begin ctl.doShift = 1'b1; ctl.shiftSel = 2'd1; end
      OP_SRA: begin ctl.doShift = 1'b1; ctl.shiftSel = 2'd2; end
      OP_LZC: ctl.doLzc = 1'b1;
      OP_FUN: ctl.doFunnel = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/lane_alu_dpath.sv
module lane_alu_dpath
  import lane_alu_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int MAX_LW  = 32,
  parameter int SH_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_W   = 3;
  localparam int BYTES   = DATA_W / 8;
  localparam int BSH_W   = $clog2(BYTES);

  logic [DATA_W-1:0] widthRes [NUM_W];
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] funnelRes;
  logic [DATA_W-1:0] nextRes;
  logic [2*DATA_W-1:0] joined;

  for (genvar g = 0; g < NUM_W; g++) begin : gWidth
    localparam int W  = MAX_LW >> g;
    localparam int NL = DATA_W / W;
    localparam int SW = $clog2(W);
    logic [DATA_W-1:0] packedRes;

    for (genvar l = 0; l < NL; l++) begin : gLane
      logic [W-1:0]  laneA, laneB, laneR;
      logic [SW-1:0] shLane;
      int            zeroCnt;
      assign laneA  = opA[l*W +: W];
      assign laneB  = opB[l*W +: W];
      assign shLane = shAmt[SW-1:0];

      always_comb begin
        zeroCnt = W;
        for (int i = 0; i < W; i++) begin
          if (laneA[i]) zeroCnt = W - 1 - i;
        end
      end

      always_comb begin
        laneR = '0;
        if (ctl.doArith) begin
          laneR = ctl.doSub ? laneA - laneB : laneA + laneB;
        end else if (ctl.doMin) begin
          laneR = ($signed(laneA) < $signed(laneB)) ? laneA : laneB;
        end else if (ctl.doMax) begin
          laneR = ($signed(laneA) > $signed(laneB)) ? laneA : laneB;
        end else if (ctl.doShift) begin
          case (ctl.shiftSel)
            2'd0:    laneR = laneA << shLane;
            2'd1:    laneR = laneA >> shLane;
            default: laneR = W'($signed(laneA) >>> shLane);
          endcase
        end else if (ctl.doLzc) begin
          laneR = W'(zeroCnt);
        end
      end

      assign packedRes[l*W +: W] = laneR;
    end

    assign widthRes[g] = packedRes;
  end

  always_comb begin
    case (ctl.logicSel)
      2'd0:    logicRes = opA & opB;
      2'd1:    logicRes = opA | opB;
      2'd2:    logicRes = opA ^ opB;
      default: logicRes = ~(opA | opB);
    endcase
  end

  assign joined    = {opA, opB} >> {shAmt[BSH_W-1:0], 3'b000};
  assign funnelRes = joined[DATA_W-1:0];

  always_comb begin
    if (ctl.doLogic)       nextRes = logicRes;
    else if (ctl.doFunnel) nextRes = funnelRes;
    else                   nextRes = widthRes[ctl.widthIdx];
  end

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (ctl.load) result <= nextRes;
  end
endmodule

// File: rtl/lane_alu128.sv
module lane_alu128
  import lane_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [3:0]   opCode,
  input  logic [1:0]   laneSel,
  input  logic [4:0]   shAmt,
  output logic         outValid,
  output logic [127:0] result
);
  aluCtl_t ctl;

  lane_alu_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .laneSel(laneSel), .ctl(ctl), .outValid(outValid)
  );

  lane_alu_dpath #(.DATA_W(128), .MAX_LW(32), .SH_W(5)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .opA(opA), .opB(opB),
    .shAmt(shAmt), .result(result)
  );
endmodule

// File: rtl/lane_alu128_chk.sv
module lane_alu128_chk (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [127:0] opA,
  input logic [127:0] opB,
  input logic [3:0]   opCode,
  input logic [1:0]   laneSel,
  input logic [4:0]   shAmt,
  input logic         outValid,
  input logic [127:0] result
);
  // R8: valid follows input valid by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R8: reset clears the outputs
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));
  // R9: result held on idle cycles
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));
  // R4: XOR matches full-width operands
  a_r4_xor_full: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'd6) |=> result == ($past(opA) ^ $past(opB)));
  // R7: zero byte shift returns B
  a_r7_funnel_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'd12 && shAmt[3:0] == 4'd0) |=> result == $past(opB));
  // R10: spare opcodes give zero
  a_r10_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode >= 4'd13) |=> result == '0);
endmodule

bind lane_alu128 lane_alu128_chk chk_i (.*);

// File: tb/lane_alu128_tb_top.sv
module lane_alu128_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [127:0] opA, opB;
  logic [3:0]   opCode;
  logic [1:0]   laneSel;
  logic [4:0]   shAmt;
  logic         outValid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [127:0] expHeld = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_alu128 dut_i (.*);

  function automatic string tagOf(input int op);
    if (op <= 1)  return "R2";
    if (op <= 3)  return "R3";
    if (op <= 7)  return "R4";
    if (op <= 10) return "R5";
    if (op == 11) return "R6";
    if (op == 12) return "R7";
    return "R10";
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input int op, input int ls, input int sh);
    logic [127:0] res = '0;
    logic [255:0] cat;
    int w = (ls == 0) ? 32 : (ls == 1) ? 16 : 8;
    longint full = longint'(1) << w;
    longint msk  = full - 1;
    if (op == 4) return a & b;
    if (op == 5) return a | b;
    if (op == 6) return a ^ b;
    if (op == 7) return ~(a | b);
    if (op == 12) begin
      cat = {a, b};
      cat = cat >> (8 * (sh % 16));
      return cat[127:0];
    end
    if (op > 12) return '0;
    for (int i = 0; i < 128 / w; i++) begin
      longint x  = longint'((a >> (i * w)) & 128'(msk));
      longint y  = longint'((b >> (i * w)) & 128'(msk));
      longint sx = (x >= full / 2) ? x - full : x;
      longint sy = (y >= full / 2) ? y - full : y;
      int     s  = sh % w;
      longint r  = 0;
      case (op)
        0: r = x + y;
        1: r = x - y;
        2: r = (sx < sy) ? x : y;
        3: r = (sx > sy) ? x : y;
        8: r = x << s;
        9: r = x >> s;
        10: r = sx >>> s;
        default: begin
          r = w;
          for (int k = w - 1; k >= 0; k--) if (x[k]) begin r = w - 1 - k; break; end
        end
      endcase
      res = res | (128'(r & msk) << (i * w));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check at next negedge
  task automatic step(input bit v, input logic [127:0] a, input logic [127:0] b,
                      input int op, input int ls, input int sh);
    logic [127:0] exp;
    inValid = v; opA = a; opB = b;
    opCode = 4'(op); laneSel = 2'(ls); shAmt = 5'(sh);
    exp = v ? model(a, b, op, ls, sh) : expHeld;
    @(negedge clk);
    check("R8 valid", {127'd0, outValid}, {127'd0, v});
    if (v) check(ls == 0 ? tagOf(op) : (op >= 4 && op <= 7) || op >= 12 ? tagOf(op) : {tagOf(op), "/R1"},
                 result, exp);
    else   check("R9 hold", result, exp);
    expHeld = exp;
  endtask

  initial begin
    rst = 1'b1; inValid = 0; opA = '0; opB = '0; opCode = 0; laneSel = 0; shAmt = 0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {127'd0, outValid}, 128'd0);
    check("R8 reset result", result, '0);
    rst = 1'b0;

    // Directed corner cases
    for (int ls = 0; ls < 4; ls++) begin
      step(1, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 0, ls, 0);   // R2 carry must not leak
      step(1, '0, {4{32'h0000_0001}}, 1, ls, 0);                   // R2 borrow must not leak
      step(1, {4{32'h8000_7F80}}, {4{32'h7FFF_8001}}, 2, ls, 0);   // R3 sign top bit
      step(1, {4{32'h8000_7F80}}, {4{32'h7FFF_8001}}, 3, ls, 0);
      step(1, {4{32'h8080_8080}}, '0, 8, ls, 31);                  // R5 max amount
      step(1, {4{32'h8080_8080}}, '0, 9, ls, 31);
      step(1, {4{32'h8080_8080}}, '0, 10, ls, 31);
      step(1, {32'h0, 32'h0000_0001, 32'h00F0_0100, 32'h8000_0000}, '0, 11, ls, 0); // R6
    end
    step(0, '1, '1, 0, 0, 0);                                      // R9 idle
    step(0, '0, '1, 5, 1, 3);                                      // R9 idle
    for (int op = 4; op < 8; op++)
      step(1, 128'hF0F0_1234_5678_9ABC_DEF0_0FF0_AAAA_5555, 128'h0FF0_FFFF_0000_1357_2468_F00F_5555_5555, op, 2, 0);
    for (int n = 0; n < 16; n++)
      step(1, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
              128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 12, 0, n + 16 * (n & 1)); // R7
    for (int op = 13; op < 16; op++) step(1, '1, '1, op, 0, 0);   // R10

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0,
           {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           int'($urandom % 16), int'($urandom % 4), int'($urandom % 32));
    end

    // R8: reset mid-stream
    inValid = 1; opCode = 0; opA = '1; opB = '1; rst = 1'b1;
    @(negedge clk);
    check("R8 reset valid", {127'd0, outValid}, 128'd0);
    check("R8 reset result", result, '0);
    rst = 1'b0; inValid = 0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule